// File: doc/BRIEF.md
# Dispatch Resource Credit Limiter

This block sits in the rename stage of an out-of-order core. Each cycle it works out how many instructions rename may pass on to dispatch. It bases that number on the free-entry counts that three downstream structures report: the reorder buffer, the issue queue and the load/store queue. Those counts arrive late and are stale. The block therefore keeps its own count of instructions that have been renamed but not yet dispatched, and subtracts that in-flight count from each stored free count. The current cycle's dispatch count is added back, because those instructions have just left flight. The load/store queue uses a separate count of dispatches that went to that queue.

The block takes the smallest of the three corrected counts as the limit. It grants that many instructions, capped by the instructions available and by the rename width. It raises a block flag when the downstream resources cut the grant short, and it names the structure that set the limit. The grant is fed back into the in-flight counter, and the counter is guarded against underflow. The reorder buffer's empty indication is latched together with its free count.

Top module: `dispatch_credit_limiter`

## Requirements
- R1: The corrected free count of the reorder buffer and of the issue queue is the stored count minus (in-flight minus dispatched this cycle). The load/store queue uses the dispatched-to-load/store-queue count instead. All three are computed in signed arithmetic, so they may go negative.
- R2: A stored free count is replaced only in a cycle where its valid input is 1. The stored empty flag is replaced only with the reorder-buffer valid. Otherwise both keep their previous value.
- R3: The limit is the smallest corrected count. On a tie the reorder buffer wins over the issue queue, and the issue queue wins over the load/store queue. The limit_src_o encoding is 0 = none, 1 = reorder buffer, 2 = issue queue, 3 = load/store queue.
- R4: If available > 0 and the limit is at most 0, then grant_o = 0, block_o = 1 and limit_src_o names the limiting structure.
- R5: If 0 < limit < available, then grant_o = min(limit, width_i), block_o = 1 and limit_src_o names the limiting structure.
- R6: If limit >= available > 0, then grant_o = min(available, width_i), block_o = 0 and limit_src_o = 0.
- R7: If available = 0, then grant_o = 0, block_o = 0 and limit_src_o = 0, whatever the free counts are.
- R8: On each clock edge, inflight_o becomes inflight_o + grant_o − disp_cnt_i.
- R9: If inflight_o + grant_o < disp_cnt_i, underflow_o is 1 in that same cycle and inflight_o becomes 0 at the next edge.
- R10: Reset sets inflight_o to 0, all three stored free counts to 0, and the empty flag rob_empty_o to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rob_free_i | input | CNT_W | Reported free reorder-buffer entries |
| rob_free_vld_i | input | 1 | Store rob_free_i and rob_empty_i this cycle |
| rob_empty_i | input | 1 | Reported reorder-buffer empty indication |
| iq_free_i | input | CNT_W | Reported free issue-queue entries |
| iq_free_vld_i | input | 1 | Store iq_free_i this cycle |
| lsq_free_i | input | CNT_W | Reported free load/store-queue entries |
| lsq_free_vld_i | input | 1 | Store lsq_free_i this cycle |
| disp_cnt_i | input | GW | Instructions dispatched this cycle |
| disp_lsq_cnt_i | input | GW | Instructions dispatched to the load/store queue this cycle |
| avail_i | input | GW | Instructions waiting to be renamed |
| width_i | input | GW | Current rename width |
| grant_o | output | GW | Instructions allowed this cycle |
| block_o | output | 1 | Downstream resources cut the grant short |
| limit_src_o | output | 2 | Limiting structure code (R3) |
| inflight_o | output | IFW | Renamed but not yet dispatched count |
| rob_empty_o | output | 1 | Latched reorder-buffer empty flag |
| underflow_o | output | 1 | In-flight count would go below zero |

## Verification
The bench targets the tie orderings between the three structures. A reversed comparison would name the issue queue or the load/store queue where the reorder buffer should win. It drives corrected counts negative through a preloaded in-flight count; unsigned arithmetic would wrap there and grant far too much. It gives the load/store queue a dispatch count that differs from the main one, which exposes a design that corrects that queue with the wrong count. It also tests a limit exactly equal to the available count, where an off-by-one comparison raises block falsely. It tests a width below the limit, where a missing clamp overgrants. Finally, it forces an in-flight underflow, which a design without the guard would turn into a huge positive count.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
   typedef enum logic [1:0] {
      LIM_NONE = 2'd0,
      LIM_ROB  = 2'd1,
      LIM_IQ   = 2'd2,
      LIM_LSQ  = 2'd3
   } lim_src_e;

   localparam int unsigned NUM_RES = 3;
   localparam int unsigned IDX_ROB = 0;
   localparam int unsigned IDX_IQ  = 1;
   localparam int unsigned IDX_LSQ = 2;
endpackage

// File: rtl/dcl_free_track.sv
// Holds one structure's last reported free count and produces the
// in-flight-corrected signed count.
module dcl_free_track #(
   parameter int CNT_W = 6,
   parameter int IFW   = 7,
   parameter int GW    = 4,
   parameter int SW    = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CNT_W-1:0]     free_in,
   input  logic                 free_vld,
   input  logic [IFW-1:0]       inflight,
   input  logic [GW-1:0]        disp,
   output logic signed [SW-1:0] eff
);
   logic [CNT_W-1:0] free_q;
   logic signed [SW-1:0] free_s, infl_s, disp_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        free_q <= '0;
      else if (free_vld) free_q <= free_in;
   end

   assign free_s = SW'(free_q);
   assign infl_s = SW'(inflight);
   assign disp_s = SW'(disp);
   assign eff    = free_s - (infl_s - disp_s);
endmodule

// File: rtl/dcl_min_select.sv
// Three-way signed minimum; earlier input wins a tie.
module dcl_min_select #(
   parameter int SW = 9
) (
   input  logic signed [SW-1:0] v_rob,
   input  logic signed [SW-1:0] v_iq,
   input  logic signed [SW-1:0] v_lsq,
   output logic signed [SW-1:0] min_v,
   output logic [1:0]           min_src
);
   import dcl_pkg::*;
   logic signed [SW-1:0] stage_v;
   lim_src_e             stage_s;

   always_comb begin
      stage_v = v_rob;
      stage_s = LIM_ROB;
      if (v_iq < stage_v) begin
         stage_v = v_iq;
         stage_s = LIM_IQ;
      end
      min_v   = stage_v;
      min_src = stage_s;
      if (v_lsq < stage_v) begin
         min_v   = v_lsq;
         min_src = LIM_LSQ;
      end
   end
endmodule

// File: rtl/dcl_inflight.sv
// Renamed-but-not-dispatched counter with underflow guard.
module dcl_inflight #(
   parameter int IFW = 7,
   parameter int GW  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [GW-1:0]  add,
   input  logic [GW-1:0]  sub,
   output logic [IFW-1:0] count,
   output logic           under
);
   localparam int XW = IFW + 1;
   logic [XW-1:0] sum_x, sub_x;
   logic [IFW-1:0] count_d;

   assign sum_x = XW'(count) + XW'(add);
   assign sub_x = XW'(sub);
   assign under = (sum_x < sub_x);

   always_comb begin
      if (under) count_d = '0;
      else       count_d = IFW'(sum_x - sub_x);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count_d;
   end
endmodule

// File: rtl/dispatch_credit_limiter.sv
module dispatch_credit_limiter #(
   parameter int CNT_W     = 6,
   parameter int WIDTH_MAX = 8,
   parameter int IFW       = 7,
   localparam int GW       = $clog2(WIDTH_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rob_free_i,
   input  logic             rob_free_vld_i,
   input  logic             rob_empty_i,
   input  logic [CNT_W-1:0] iq_free_i,
   input  logic             iq_free_vld_i,
   input  logic [CNT_W-1:0] lsq_free_i,
   input  logic             lsq_free_vld_i,
   input  logic [GW-1:0]    disp_cnt_i,
   input  logic [GW-1:0]    disp_lsq_cnt_i,
   input  logic [GW-1:0]    avail_i,
   input  logic [GW-1:0]    width_i,
   output logic [GW-1:0]    grant_o,
   output logic             block_o,
   output logic [1:0]       limit_src_o,
   output logic [IFW-1:0]   inflight_o,
   output logic             rob_empty_o,
   output logic             underflow_o
);
   import dcl_pkg::*;

   localparam int SW = ((CNT_W > IFW) ? CNT_W : IFW) + 2;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (WIDTH_MAX < 1) begin : g_bad_width
      $error("WIDTH_MAX must be at least 1");
   end
   if (IFW < GW) begin : g_bad_ifw
      $error("IFW must hold at least one full rename group");
   end

   logic [CNT_W-1:0]     res_free [NUM_RES];
   logic                 res_vld  [NUM_RES];
   logic [GW-1:0]        res_disp [NUM_RES];
   logic signed [SW-1:0] res_eff  [NUM_RES];

   assign res_free[IDX_ROB] = rob_free_i;
   assign res_free[IDX_IQ]  = iq_free_i;
   assign res_free[IDX_LSQ] = lsq_free_i;
   assign res_vld[IDX_ROB]  = rob_free_vld_i;
   assign res_vld[IDX_IQ]   = iq_free_vld_i;
   assign res_vld[IDX_LSQ]  = lsq_free_vld_i;

   for (genvar g = 0; g < NUM_RES; g++) begin : g_res
      if (g == IDX_LSQ) begin : g_mem
         assign res_disp[g] = disp_lsq_cnt_i;
      end else begin : g_gen
         assign res_disp[g] = disp_cnt_i;
      end

      dcl_free_track #(
         .CNT_W (CNT_W),
         .IFW   (IFW),
         .GW    (GW),
         .SW    (SW)
      ) u_trk (
         .clk      (clk),
         .rst_n    (rst_n),
         .free_in  (res_free[g]),
         .free_vld (res_vld[g]),
         .inflight (inflight_o),
         .disp     (res_disp[g]),
         .eff      (res_eff[g])
      );
   end

   // Empty flag travels with the reorder-buffer count.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rob_empty_o <= 1'b1;
      else if (rob_free_vld_i) rob_empty_o <= rob_empty_i;
   end

   logic signed [SW-1:0] min_v;
   logic [1:0]           min_src;

   dcl_min_select #(.SW(SW)) u_min (
      .v_rob   (res_eff[IDX_ROB]),
      .v_iq    (res_eff[IDX_IQ]),
      .v_lsq   (res_eff[IDX_LSQ]),
      .min_v   (min_v),
      .min_src (min_src)
   );

   logic signed [SW-1:0] avail_s, width_s, cap_s, cap2_s;
   logic                 short_res;

   assign avail_s = SW'(avail_i);
   assign width_s = SW'(width_i);

   always_comb begin
      short_res   = 1'b0;
      cap_s       = '0;
      cap2_s      = '0;
      grant_o     = '0;
      block_o     = 1'b0;
      limit_src_o = LIM_NONE;
      if (avail_i == '0) begin
         grant_o = '0;
      end else if (min_v <= 0) begin
         block_o     = 1'b1;
         limit_src_o = min_src;
      end else begin
         short_res = (min_v < avail_s);
         cap_s     = short_res ? min_v : avail_s;
         cap2_s    = (cap_s < width_s) ? cap_s : width_s;
         grant_o   = GW'(cap2_s);
         block_o   = short_res;
         if (short_res) limit_src_o = min_src;
      end
   end

   dcl_inflight #(.IFW(IFW), .GW(GW)) u_infl (
      .clk   (clk),
      .rst_n (rst_n),
      .add   (grant_o),
      .sub   (disp_cnt_i),
      .count (inflight_o),
      .under (underflow_o)
   );
endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
   parameter int GW  = 4,
   parameter int IFW = 7
) (
   input logic           clk,
   input logic           rst_n,
   input logic           rob_free_vld_i,
   input logic [GW-1:0]  disp_cnt_i,
   input logic [GW-1:0]  avail_i,
   input logic [GW-1:0]  width_i,
   input logic [GW-1:0]  grant_o,
   input logic           block_o,
   input logic [1:0]     limit_src_o,
   input logic [IFW-1:0] inflight_o,
   input logic           rob_empty_o,
   input logic           underflow_o
);
   // R5
   grant_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o <= width_i);

   // R4
   block_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      block_o |-> (grant_o < avail_i) && (limit_src_o != 2'd0));

   // R6
   quiet_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !block_o |-> limit_src_o == 2'd0);

   // R7
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (avail_i == '0) |-> (grant_o == '0) && !block_o);

   // R8
   inflight_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !underflow_o |=> inflight_o ==
         IFW'($past(inflight_o) + IFW'($past(grant_o)) - IFW'($past(disp_cnt_i))));

   // R9
   underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_o |=> inflight_o == '0);

   // R2
   rob_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rob_free_vld_i |=> $stable(rob_empty_o));
endmodule

bind dispatch_credit_limiter dcl_checker #(.GW(GW), .IFW(IFW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rob_free_vld_i (rob_free_vld_i),
   .disp_cnt_i     (disp_cnt_i),
   .avail_i        (avail_i),
   .width_i        (width_i),
   .grant_o        (grant_o),
   .block_o        (block_o),
   .limit_src_o    (limit_src_o),
   .inflight_o     (inflight_o),
   .rob_empty_o    (rob_empty_o),
   .underflow_o    (underflow_o)
);

// File: tb/dispatch_credit_limiter_test.sv
`timescale 1ns/1ps
module dispatch_credit_limiter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] rob_free, iq_free, lsq_free;
   logic       rob_vld, iq_vld, lsq_vld, rob_empty;
   logic [3:0] disp, disp_lsq, avail, width;
   logic [3:0] grant;
   logic       block, under, rob_empty_q;
   logic [1:0] src;
   logic [6:0] inflight;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dispatch_credit_limiter uut (
      .clk(clk), .rst_n(rst_n),
      .rob_free_i(rob_free), .rob_free_vld_i(rob_vld), .rob_empty_i(rob_empty),
      .iq_free_i(iq_free), .iq_free_vld_i(iq_vld),
      .lsq_free_i(lsq_free), .lsq_free_vld_i(lsq_vld),
      .disp_cnt_i(disp), .disp_lsq_cnt_i(disp_lsq),
      .avail_i(avail), .width_i(width),
      .grant_o(grant), .block_o(block), .limit_src_o(src),
      .inflight_o(inflight), .rob_empty_o(rob_empty_q), .underflow_o(under)
   );

   // pre, rob, iq, lsq, avail, width, disp, dlsq, grant, block, src, req
   localparam int NV = 14;
   localparam int VEC [NV][12] = '{
      '{0, 20, 20, 20, 4, 4, 0, 0, 4, 0, 0, 6},  // R6 plenty
      '{0,  3, 10, 10, 6, 8, 0, 0, 3, 1, 1, 5},  // R5 rob short
      '{0, 10,  2, 10, 6, 8, 0, 0, 2, 1, 2, 5},  // R5 iq short
      '{0, 10, 10,  1, 6, 8, 0, 0, 1, 1, 3, 5},  // R5 lsq short
      '{0,  2,  2,  2, 5, 8, 0, 0, 2, 1, 1, 3},  // R3 three-way tie
      '{0,  9,  3,  3, 5, 8, 0, 0, 3, 1, 2, 3},  // R3 iq/lsq tie
      '{0,  0,  5,  5, 3, 8, 0, 0, 0, 1, 1, 4},  // R4 zero
      '{5,  3, 20, 20, 2, 8, 0, 0, 0, 1, 1, 4},  // R4 negative via inflight
      '{5,  3, 20, 20, 2, 8, 4, 0, 2, 0, 0, 1},  // R1 dispatch adds back
      '{6, 30, 30,  6, 4, 8, 6, 1, 1, 1, 3, 1},  // R1 lsq own count
      '{0, 30, 30, 30, 7, 3, 0, 0, 3, 0, 0, 6},  // R6 width clamp
      '{0,  0,  0,  0, 0, 8, 0, 0, 0, 0, 0, 7},  // R7 nothing available
      '{0,  4,  9,  9, 4, 8, 0, 0, 4, 0, 0, 6},  // R6 limit equals avail
      '{0,  5,  9,  9, 7, 2, 0, 0, 2, 1, 1, 5}   // R5 width below limit
   };

   function automatic string req_name(input int r);
      case (r)
         1: return "R1";  2: return "R2";  3: return "R3";
         4: return "R4";  5: return "R5";  6: return "R6";
         7: return "R7";  8: return "R8";  9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      rob_free = '0; iq_free = '0; lsq_free = '0;
      rob_vld = 0; iq_vld = 0; lsq_vld = 0; rob_empty = 0;
      disp = '0; disp_lsq = '0; avail = '0; width = 4'd8;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      idle_inputs();
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic run_vec(input int i);
      do_reset();
      rob_free = 6'd63; iq_free = 6'd63; lsq_free = 6'd63;
      rob_vld = 1; iq_vld = 1; lsq_vld = 1;
      @(negedge clk);
      rob_free = 6'(VEC[i][1]); iq_free = 6'(VEC[i][2]); lsq_free = 6'(VEC[i][3]);
      avail = 4'(VEC[i][0]); width = 4'd8;
      @(negedge clk);
      rob_vld = 0; iq_vld = 0; lsq_vld = 0;
      rob_free = '0; iq_free = '0; lsq_free = '0;
      avail = 4'(VEC[i][4]); width = 4'(VEC[i][5]);
      disp = 4'(VEC[i][6]); disp_lsq = 4'(VEC[i][7]);
      #1;
      check(req_name(VEC[i][11]), $sformatf("vec%0d grant", i), int'(grant), VEC[i][8]);
      check(req_name(VEC[i][11]), $sformatf("vec%0d block", i), int'(block), VEC[i][9]);
      check(req_name(VEC[i][11]), $sformatf("vec%0d src", i), int'(src), VEC[i][10]);
   endtask

   initial begin
      idle_inputs();
      for (int i = 0; i < NV; i++) run_vec(i);

      // R10 reset state
      do_reset();
      #1;
      check("R10", "inflight after reset", int'(inflight), 0);
      check("R10", "empty flag after reset", int'(rob_empty_q), 1);
      check("R9", "no underflow after reset", int'(under), 0);
      avail = 4'd3;
      #1;
      check("R10", "stored zero counts grant", int'(grant), 0);
      check("R4", "stored zero counts src", int'(src), 1);

      // R2 valid gating
      @(negedge clk);
      avail = '0;
      rob_free = 6'd10; rob_vld = 1; rob_empty = 0;
      iq_free = 6'd40; iq_vld = 1; lsq_free = 6'd40; lsq_vld = 1;
      @(negedge clk);
      check("R10", "empty flag latched with count", int'(rob_empty_q), 0);
      rob_free = 6'd1; rob_vld = 0; rob_empty = 1; iq_vld = 0; lsq_vld = 0;
      avail = 4'd8; width = 4'd8;
      #1;
      check("R2", "unlatched count ignored grant", int'(grant), 8);
      check("R2", "unlatched count ignored block", int'(block), 0);
      @(negedge clk);
      check("R2", "empty flag held", int'(rob_empty_q), 0);
      check("R8", "inflight after grant", int'(inflight), 8);
      avail = '0; disp = 4'd3; disp_lsq = 4'd3;
      @(negedge clk);
      check("R8", "inflight after dispatch", int'(inflight), 5);
      disp = 4'd9;
      #1;
      check("R9", "underflow flagged", int'(under), 1);
      @(negedge clk);
      check("R9", "inflight clamped", int'(inflight), 0);
      disp = '0;
      #1;
      check("R9", "underflow clears", int'(under), 0);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule